// File: doc/BRIEF.md
# Power-Good Flag Generator

This block decides when a switching regulator controller reports its output as good. It takes three digitized comparator results (feedback above the over-voltage level, feedback below the under-voltage level, output at or above the good level), a soft-start-done flag, a strobe that marks a change of the output setpoint, a controller enable, a system clock and a periodic time-base tick. It produces an active-high power-good flag and its complement, which enables the pull-down transistor of an open-drain pin.

The flag follows a target condition: enabled, soft-start finished, output at the good level, and neither fault comparator active. A change of the flag is accepted only after the target has disagreed with the flag for a parameterized number of consecutive ticks. A short disagreement clears the count. After a setpoint change the flag is frozen for a fixed number of clock cycles while the output moves to its new level. Disabling the controller clears the flag at once.

Top module: `pgood_gen`

## Requirements
- R1: While reset is asserted, and one cycle after `en_i` is sampled low, `pgood_o` is 0.
- R2: `pull_low_o` is always the inverse of `pgood_o`.
- R3: With `en_i`, `ss_done_i` and `lvl_ok_i` at 1 and `ov_i`, `uv_i` at 0, `pgood_o` rises once that condition has held through `FILT_TICKS` tick cycles.
- R4: While `pgood_o` is 1, either `ov_i` or `uv_i` held at 1 through `FILT_TICKS` tick cycles clears `pgood_o`.
- R5: If the target condition returns to match `pgood_o` before `FILT_TICKS` ticks, the tick count restarts and `pgood_o` does not change.
- R6: While `ss_done_i` is 0, a low `pgood_o` stays low.
- R7: A pulse on `vsel_chg_i` holds `pgood_o` at its value for `HOLD_CYC` cycles, counting the pulse cycle.
- R8: A `vsel_chg_i` pulse inside an active hold window restarts the full window.
- R9: Apart from a disable, `pgood_o` changes only at an edge where `tick_i` was sampled 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Controller enable |
| tick_i | input | 1 | Time-base tick, one cycle wide |
| ov_i | input | 1 | Feedback above over-voltage level |
| uv_i | input | 1 | Feedback below under-voltage level |
| lvl_ok_i | input | 1 | Output at or above the good level |
| ss_done_i | input | 1 | Soft-start finished |
| vsel_chg_i | input | 1 | Setpoint change strobe |
| pgood_o | output | 1 | Power-good flag, active high |
| pull_low_o | output | 1 | Pull-down enable for the open-drain pin |

## Verification
The flag is registered, so a disable shows one edge after `en_i` is sampled low, a filtered change shows at the edge of the tick that completes the count, and a hold window covers the strobe cycle plus the following `HOLD_CYC-1` edges. The bench drives inputs on the falling edge and keeps a cycle-level expectation updated on the rising edge from the requirements; it compares every output on the next falling edge, so each result is checked in the cycle it is due. Directed phases check the soft-start gate, a short fault glitch, a long fault, and a restarted hold window at hand-counted cycle offsets.

// File: rtl/pgood_gen.sv
module pgood_gen #(
  parameter int FILT_TICKS = 10,
  parameter int HOLD_CYC   = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic tick_i,
  input  logic ov_i,
  input  logic uv_i,
  input  logic lvl_ok_i,
  input  logic ss_done_i,
  input  logic vsel_chg_i,
  output logic pgood_o,
  output logic pull_low_o
);
  localparam int FW = $clog2(FILT_TICKS + 1);
  localparam int HW = $clog2(HOLD_CYC + 1);

  logic [FW-1:0] filt_q;
  logic [HW-1:0] hold_q;

  wire want   = ss_done_i & lvl_ok_i & ~ov_i & ~uv_i;
  wire frozen = vsel_chg_i | (hold_q != '0);
  wire differ = want != pgood_o;

  assign pull_low_o = ~pgood_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          hold_q <= '0;
    else if (!en_i)       hold_q <= '0;
    else if (vsel_chg_i)  hold_q <= HW'(HOLD_CYC - 1);
    else if (hold_q != '0) hold_q <= hold_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pgood_o <= 1'b0;
      filt_q  <= '0;
    end else if (!en_i) begin
      pgood_o <= 1'b0;
      filt_q  <= '0;
    end else if (frozen || !differ) begin
      filt_q  <= '0;
    end else if (tick_i) begin
      if (filt_q == FW'(FILT_TICKS - 1)) begin
        pgood_o <= want;
        filt_q  <= '0;
      end else begin
        filt_q  <= filt_q + 1'b1;
      end
    end
  end

  // R1
  disabled_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !pgood_o);

  // R6
  ss_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ss_done_i && !pgood_o) |=> !pgood_o);

  // R7
  strobe_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && vsel_chg_i) |=> $stable(pgood_o));

  // R9
  tick_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !tick_i) |=> $stable(pgood_o));
endmodule

// File: tb/sim_pgood_gen.sv
module sim_pgood_gen;
  localparam int F    = 4;
  localparam int HOLD = 32;
  localparam int TP   = 2;

  logic clk = 0, rst_n = 0;
  logic en = 0, tick = 0, ov = 0, uv = 0, lvl = 0, ss = 0, chg = 0;
  logic pg, pl;
  int total = 0, bad = 0, cyc = 0, tcnt = 0;

  logic m_pg = 0;
  int   m_cnt = 0, m_hold = 0;

  always #4 clk = ~clk;

  pgood_gen #(.FILT_TICKS(F), .HOLD_CYC(HOLD)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .tick_i(tick), .ov_i(ov), .uv_i(uv),
    .lvl_ok_i(lvl), .ss_done_i(ss), .vsel_chg_i(chg), .pgood_o(pg), .pull_low_o(pl));

  function automatic logic target(logic e, logic s, logic l, logic o, logic u);
    return e & s & l & ~o & ~u;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || !en) begin
      m_pg <= 0; m_cnt <= 0; m_hold <= 0;
    end else begin
      m_hold <= chg ? HOLD - 1 : (m_hold > 0 ? m_hold - 1 : 0);
      if (chg || m_hold > 0 || target(en, ss, lvl, ov, uv) == m_pg) m_cnt <= 0;
      else if (tick) begin
        if (m_cnt == F - 1) begin m_pg <= ~m_pg; m_cnt <= 0; end
        else m_cnt <= m_cnt + 1;
      end
    end
  end

  task automatic check(string req, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b cycle=%0d", req, act, exp, cyc);
    end
  endtask

  task automatic step();
    @(negedge clk);
    check("R1/R3/R4/R5/R7/R8/R9 model", pg, m_pg);
    check("R2 complement", pl, ~pg);
    tcnt = (tcnt + 1) % TP;
    tick = (tcnt == 0);
  endtask

  task automatic steps(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    steps(3);
    check("R1 reset low", pg, 1'b0);
    check("R2 reset pull", pl, 1'b1);
    rst_n = 1;
    en = 1; lvl = 1; ss = 0;
    steps(30);
    check("R6 softstart gate", pg, 1'b0);
    ss = 1;
    steps(20);
    check("R3 rise", pg, 1'b1);
    ov = 1; steps(3); ov = 0;
    steps(20);
    check("R5 glitch ignored", pg, 1'b1);
    chg = 1; uv = 1; step(); chg = 0;
    steps(23);
    check("R7 hold", pg, 1'b1);
    chg = 1; step(); chg = 0;
    steps(25);
    check("R8 restart", pg, 1'b1);
    steps(30);
    check("R4 fall", pg, 1'b0);
    uv = 0;
    steps(20);
    check("R3 rise again", pg, 1'b1);
    en = 0; step();
    check("R1 disable", pg, 1'b0);
    en = 1;
    for (int ph = 0; ph < 300; ph++) begin
      int len;
      len = 1 + int'($urandom_range(0, 30));
      ov  = ($urandom_range(0, 5) == 0);
      uv  = ($urandom_range(0, 5) == 0);
      lvl = ($urandom_range(0, 4) != 0);
      ss  = ($urandom_range(0, 6) != 0);
      en  = ($urandom_range(0, 20) != 0);
      for (int k = 0; k < len; k++) begin
        chg = ($urandom_range(0, 40) == 0);
        step();
      end
      chg = 0;
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule